// File: doc/BRIEF.md
# Shared Main-RAM Access Arbiter

This block shares one single-port word RAM between a host processor and an internal burst engine. The engine moves a fully checked message between a 32-word staging buffer and main RAM. The host talks to the RAM through a level request. It receives an active-low acknowledge once the access has been carried out. Read data is valid while that acknowledge is low.

A burst is announced before it runs. A start pulse opens a fixed warning window, during which the strobe output is held low. Host cycles that were already acknowledged may finish inside this window. Host requests that arrive after the window has opened are parked without acknowledge until the burst is over.

When the window closes, the engine copies the requested number of words without a break. In fetch direction it copies from RAM to the staging buffer, and in store direction from the staging buffer to RAM. Each word takes a fixed slot: 16 cycles when fetching and 8 cycles when storing. A start flagged as belonging to a mode command never opens a window. A lock output tells the host-side block buffer logic that it must not start a buffer-to-RAM transfer while the window or the burst is in progress.

Top module: `shared_ram_arbiter`

## Requirements
- R1: After reset `host_ack_n` and `strobe_n` are 1, and `burst_busy`, `burst_done` and `xfer_lock` are 0.
- R2: With no window or burst pending, a host request raised before clock edge k is issued to RAM at edge k. `host_ack_n` goes low after edge k+1. A write (`host_we`=1) stores `host_wdata` at `host_addr`. A read (`host_we`=0) returns the RAM word at `host_addr` on `host_rdata`.
- R3: `host_ack_n` stays low while `host_req` stays high. It returns to 1 on the first clock edge that samples `host_req` low.
- R4: A start (`burst_start`=1, `burst_mode`=0) accepted while idle drives `strobe_n` low for exactly STROBE_CYC cycles (default 136). `burst_busy` rises in the cycle right after the window closes.
- R5: A host request first raised during the window, during the burst, or in the same cycle as an accepted start gets no acknowledge while the window or burst lasts. It is acknowledged two cycles after `burst_busy` falls.
- R6: A host access acknowledged before a start keeps `host_ack_n` low through the start. It releases per R3.
- R7: Fetch (`burst_dir`=1) copies N = `burst_cnt_m1`+1 words (1 to 32), RAM[`burst_base`+i] to staging[i]. `burst_busy` lasts N*16 cycles.
- R8: Store (`burst_dir`=0) copies staging[i] to RAM[`burst_base`+i] for N words. `burst_busy` lasts N*8 cycles.
- R9: `burst_done` is high for exactly one cycle per burst. That cycle is the one in which the last word is written to its destination, i.e. busy cycle (N-1)*slot+1, counted from 0.
- R10: A start with `burst_mode`=1 is ignored: `strobe_n` stays 1 and host requests are served per R2.
- R11: A start while the window or burst is active is ignored, and the running window and burst keep their lengths.
- R12: `xfer_lock` is 1 exactly while `strobe_n` is 0 or `burst_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request (level) |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | ADDR_W | Host RAM address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, valid while acknowledged |
| host_ack_n | output | 1 | Active-low acknowledge |
| burst_start | input | 1 | Request a burst (one-cycle pulse) |
| burst_mode | input | 1 | 1 = mode-command message, start ignored |
| burst_dir | input | 1 | 1 = fetch RAM to staging, 0 = store staging to RAM |
| burst_cnt_m1 | input | $clog2(BUF_DEPTH) | Word count minus one |
| burst_base | input | ADDR_W | First RAM address of the burst |
| strobe_n | output | 1 | Active-low warning window |
| burst_busy | output | 1 | Burst in progress |
| burst_done | output | 1 | One-cycle pulse on the last word written |
| xfer_lock | output | 1 | Blocks block-buffer to RAM transfers |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data (one cycle after `ram_en`) |
| stg_addr | output | $clog2(BUF_DEPTH) | Staging buffer address |
| stg_we | output | 1 | Staging buffer write enable |
| stg_wdata | output | DATA_W | Staging buffer write data |
| stg_rdata | input | DATA_W | Staging buffer read data (one cycle after address) |

## Verification
The hardest situations to reach from the ports are the ones where a host cycle and a burst start meet. These are a request raised in the very cycle the start is accepted, and an access already acknowledged when the start arrives. The bench drives both inputs on the same falling edge to produce the race. It also raises a start while an acknowledge is still held low, then confirms that the acknowledge neither drops nor is granted again. Further starts are pulsed inside the window and inside the burst, and the measured window, busy and done positions show that they are ignored.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        DIR_STORE = 1'b0,
        DIR_FETCH = 1'b1
    } arb_dir_e;

    typedef enum logic [1:0] {
        HP_IDLE  = 2'd0,
        HP_ISSUE = 2'd1,
        HP_ACK   = 2'd2
    } host_st_e;

    function automatic int slot_len(arb_dir_e d, int tx_pace, int rx_pace);
        return (d == DIR_FETCH) ? tx_pace : rx_pace;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/arb_strobe_timer.sv
module arb_strobe_timer #(
    parameter int CYC = 136
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active,
    output logic expire
);
    localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt;

    assign expire = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (load && !active) begin
            active <= 1'b1;
            cnt    <= CW'(CYC - 1);
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assert_window_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (active && cnt != '0) |=> active);

endmodule

// File: rtl/arb_burst_seq.sv
module arb_burst_seq
    import arb_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    parameter int TX_PACE   = 16,
    parameter int RX_PACE   = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         go,
    input  arb_dir_e                     dir,
    input  logic [$clog2(BUF_DEPTH)-1:0] last,
    output logic                         busy,
    output logic [$clog2(BUF_DEPTH)-1:0] idx,
    output logic                         phase_rd,
    output logic                         phase_wr,
    output logic                         done
);
    localparam int IW   = $clog2(BUF_DEPTH);
    localparam int MAXP = max2(TX_PACE, RX_PACE);
    localparam int PW   = $clog2(MAXP);

    logic [PW-1:0] pc;
    logic [PW-1:0] slot_max;

    assign slot_max = PW'(slot_len(dir, TX_PACE, RX_PACE) - 1);
    assign phase_rd = busy && (pc == '0);
    assign phase_wr = busy && (pc == PW'(1));
    assign done     = phase_wr && (idx == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            pc   <= '0;
        end else if (go) begin
            busy <= 1'b1;
            idx  <= '0;
            pc   <= '0;
        end else if (busy) begin
            if (pc == slot_max) begin
                pc <= '0;
                if (idx == last) busy <= 1'b0;
                else             idx  <= idx + IW'(1);
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end

    assert_idx_bound_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx <= last));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/arb_host_port.sv
module arb_host_port
    import arb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              hold,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              issue,
    output logic              ack_n,
    output logic [DATA_W-1:0] rdata
);
    host_st_e st;

    assign issue = (st == HP_IDLE) && req && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= HP_IDLE;
            ack_n <= 1'b1;
            rdata <= '0;
        end else begin
            case (st)
                HP_IDLE:  if (issue) st <= HP_ISSUE;
                HP_ISSUE: begin
                    rdata <= ram_rdata;
                    ack_n <= 1'b0;
                    st    <= HP_ACK;
                end
                HP_ACK:   if (!req) begin
                    ack_n <= 1'b1;
                    st    <= HP_IDLE;
                end
                default:  st <= HP_IDLE;
            endcase
        end
    end

    assert_ack_release_R3: assert property (@(posedge clk) disable iff (rst)
        (!req && !ack_n) |=> ack_n);

    assert_ack_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (st == HP_IDLE && hold) |=> ack_n);

endmodule

// File: rtl/shared_ram_arbiter.sv
module shared_ram_arbiter
    import arb_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 10,
    parameter int BUF_DEPTH  = 32,
    parameter int STROBE_CYC = 136,
    parameter int TX_PACE    = 16,
    parameter int RX_PACE    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         host_req,
    input  logic                         host_we,
    input  logic [ADDR_W-1:0]            host_addr,
    input  logic [DATA_W-1:0]            host_wdata,
    output logic [DATA_W-1:0]            host_rdata,
    output logic                         host_ack_n,
    input  logic                         burst_start,
    input  logic                         burst_mode,
    input  logic                         burst_dir,
    input  logic [$clog2(BUF_DEPTH)-1:0] burst_cnt_m1,
    input  logic [ADDR_W-1:0]            burst_base,
    output logic                         strobe_n,
    output logic                         burst_busy,
    output logic                         burst_done,
    output logic                         xfer_lock,
    output logic                         ram_en,
    output logic                         ram_we,
    output logic [ADDR_W-1:0]            ram_addr,
    output logic [DATA_W-1:0]            ram_wdata,
    input  logic [DATA_W-1:0]            ram_rdata,
    output logic [$clog2(BUF_DEPTH)-1:0] stg_addr,
    output logic                         stg_we,
    output logic [DATA_W-1:0]            stg_wdata,
    input  logic [DATA_W-1:0]            stg_rdata
);
    localparam int IW = $clog2(BUF_DEPTH);

    logic            win_active, win_expire, start_ok, hold, host_issue;
    logic            ph_rd, ph_wr;
    logic [IW-1:0]   idx, last_q;
    logic [ADDR_W-1:0] base_q;
    arb_dir_e        dir_q;

    assign start_ok = burst_start && !burst_mode && !win_active && !burst_busy;
    assign hold     = win_active || burst_busy || start_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= DIR_STORE;
            last_q <= '0;
            base_q <= '0;
        end else if (start_ok) begin
            dir_q  <= arb_dir_e'(burst_dir);
            last_q <= burst_cnt_m1;
            base_q <= burst_base;
        end
    end

    arb_strobe_timer #(.CYC(STROBE_CYC)) u_win (
        .clk(clk), .rst(rst), .load(start_ok),
        .active(win_active), .expire(win_expire)
    );

    arb_burst_seq #(.BUF_DEPTH(BUF_DEPTH), .TX_PACE(TX_PACE), .RX_PACE(RX_PACE)) u_seq (
        .clk(clk), .rst(rst), .go(win_expire), .dir(dir_q), .last(last_q),
        .busy(burst_busy), .idx(idx), .phase_rd(ph_rd), .phase_wr(ph_wr),
        .done(burst_done)
    );

    arb_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
        .clk(clk), .rst(rst), .req(host_req), .hold(hold),
        .ram_rdata(ram_rdata), .issue(host_issue),
        .ack_n(host_ack_n), .rdata(host_rdata)
    );

    assign strobe_n  = !win_active;
    assign xfer_lock = win_active || burst_busy;

    always_comb begin
        if (burst_busy) begin
            ram_en    = (dir_q == DIR_FETCH) ? ph_rd : ph_wr;
            ram_we    = (dir_q == DIR_STORE) && ph_wr;
            ram_addr  = base_q + ADDR_W'(idx);
            ram_wdata = stg_rdata;
        end else begin
            ram_en    = host_issue;
            ram_we    = host_issue && host_we;
            ram_addr  = host_addr;
            ram_wdata = host_wdata;
        end
    end

    assign stg_addr  = idx;
    assign stg_we    = burst_busy && (dir_q == DIR_FETCH) && ph_wr;
    assign stg_wdata = ram_rdata;

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(win_active && burst_busy));

    assert_burst_follows_R4: assert property (@(posedge clk) disable iff (rst)
        win_expire |=> burst_busy);

    assert_done_in_burst_R9: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> burst_busy);

    assert_host_off_ram_R5: assert property (@(posedge clk) disable iff (rst)
        burst_busy |-> !host_issue);

    assert_mode_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (burst_start && burst_mode && !win_active && !burst_busy) |=> !win_active);

endmodule

// File: tb/sim_shared_ram_arbiter.sv
module sim_shared_ram_arbiter;
    localparam int DW = 16, AW = 10, DEPTH = 32, SCYC = 136, TXP = 16, RXP = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic host_req = 0, host_we = 0, burst_start = 0, burst_mode = 0, burst_dir = 0;
    logic [AW-1:0] host_addr = '0, burst_base = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [4:0] burst_cnt_m1 = '0;
    logic [DW-1:0] host_rdata, ram_wdata, ram_rdata, stg_wdata, stg_rdata;
    logic host_ack_n, strobe_n, burst_busy, burst_done, xfer_lock;
    logic ram_en, ram_we, stg_we;
    logic [AW-1:0] ram_addr;
    logic [4:0] stg_addr;

    logic [DW-1:0] mem [1024];
    logic [DW-1:0] stg [DEPTH];

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    shared_ram_arbiter u0 (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack_n(host_ack_n), .burst_start(burst_start), .burst_mode(burst_mode),
        .burst_dir(burst_dir), .burst_cnt_m1(burst_cnt_m1), .burst_base(burst_base),
        .strobe_n(strobe_n), .burst_busy(burst_busy), .burst_done(burst_done),
        .xfer_lock(xfer_lock), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .stg_addr(stg_addr),
        .stg_we(stg_we), .stg_wdata(stg_wdata), .stg_rdata(stg_rdata)
    );

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            ram_rdata <= mem[ram_addr];
        end
        stg_rdata <= stg[stg_addr];
        if (stg_we) stg[stg_addr] <= stg_wdata;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {we, addr, wdata, expected read}
    localparam logic [42:0] VECS [6] = '{
        {1'b1, 10'h005, 16'hA5A5, 16'h0000},
        {1'b1, 10'h3FF, 16'h1234, 16'h0000},
        {1'b0, 10'h005, 16'h0000, 16'hA5A5},
        {1'b0, 10'h3FF, 16'h0000, 16'h1234},
        {1'b1, 10'h005, 16'h5A0F, 16'h0000},
        {1'b0, 10'h005, 16'h0000, 16'h5A0F}
    };

    task automatic host_cycle(input logic we, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, output logic [DW-1:0] rd,
                              output int lat);
        host_we = we; host_addr = a; host_wdata = d; host_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (host_ack_n && lat < 50);
        rd = host_rdata;
        repeat (3) begin
            @(negedge clk);
            check(host_ack_n == 1'b0, "R3 ack held", host_ack_n, 0);
        end
        host_req = 1'b0;
        @(negedge clk);
        check(host_ack_n == 1'b1, "R3 ack release", host_ack_n, 1);
    endtask

    task automatic run_burst(input logic dir, input int n, input logic [AW-1:0] base,
                             input int host_at, input bit retrig);
        int s_cnt = 0, b_cnt = 0, d_cnt = 0, d_pos = -1, lock_bad = 0, ack_bad = 0;
        int pace = dir ? TXP : RXP;
        burst_dir = dir; burst_cnt_m1 = 5'(n - 1); burst_base = base;
        host_we = 1'b0; host_addr = 10'h005;
        burst_start = 1'b1;
        if (host_at == 0) host_req = 1'b1;
        @(negedge clk);
        burst_start = 1'b0;
        while (strobe_n == 1'b0 && s_cnt < 1000) begin
            s_cnt++;
            if (!xfer_lock) lock_bad++;
            if (!host_ack_n) ack_bad++;
            burst_start = (retrig && s_cnt == 5);
            if (host_at > 0 && s_cnt == host_at) host_req = 1'b1;
            @(negedge clk);
        end
        burst_start = 1'b0;
        check(burst_busy == 1'b1, "R4 busy after window", burst_busy, 1);
        while (burst_busy && b_cnt < 2000) begin
            if (burst_done) begin d_cnt++; d_pos = b_cnt; end
            b_cnt++;
            if (!xfer_lock || !strobe_n) lock_bad++;
            if (!host_ack_n) ack_bad++;
            burst_start = (retrig && b_cnt == 3);
            @(negedge clk);
        end
        burst_start = 1'b0;
        check(s_cnt == SCYC, "R4 window length", s_cnt, SCYC);
        check(b_cnt == n * pace, dir ? "R7 fetch busy length" : "R8 store busy length",
              b_cnt, n * pace);
        check(d_cnt == 1, "R9 done count", d_cnt, 1);
        check(d_pos == (n - 1) * pace + 1, "R9 done position", d_pos, (n - 1) * pace + 1);
        check(lock_bad == 0 && xfer_lock == 1'b0, "R12 lock tracks window/burst", lock_bad, 0);
        if (host_req) begin
            check(ack_bad == 0 && host_ack_n, "R5 no ack while held", ack_bad, 0);
            @(negedge clk);
            check(host_ack_n == 1'b1, "R5 ack not yet", host_ack_n, 1);
            @(negedge clk);
            check(host_ack_n == 1'b0, "R5 ack after burst", host_ack_n, 0);
            host_req = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int lat;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < DEPTH; i++) stg[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(host_ack_n == 1'b1, "R1 ack_n", host_ack_n, 1);
        check(strobe_n == 1'b1, "R1 strobe_n", strobe_n, 1);
        check(!burst_busy && !burst_done, "R1 busy/done", {burst_busy, burst_done}, 0);
        check(xfer_lock == 1'b0, "R1 lock", xfer_lock, 0);

        // R2 vector walk
        for (int v = 0; v < 6; v++) begin
            host_cycle(VECS[v][42], VECS[v][41:32], VECS[v][31:16], rd, lat);
            check(lat == 2, "R2 ack latency", lat, 2);
            if (!VECS[v][42]) check(rd == VECS[v][15:0], "R2 read data", rd, VECS[v][15:0]);
        end

        // R7 fetch of 4 words
        for (int i = 0; i < 4; i++) mem[10'h040 + i] = 16'hC000 + 16'(i * 3);
        run_burst(1'b1, 4, 10'h040, -1, 1'b0);
        for (int i = 0; i < 4; i++)
            check(stg[i] == 16'hC000 + 16'(i * 3), "R7 fetched word", stg[i], 16'hC000 + i * 3);

        // R8 store of 3 words
        for (int i = 0; i < 3; i++) stg[i] = 16'h7700 + 16'(i);
        run_burst(1'b0, 3, 10'h100, -1, 1'b0);
        for (int i = 0; i < 3; i++)
            check(mem[10'h100 + i] == 16'h7700 + 16'(i), "R8 stored word", mem[10'h100 + i], 16'h7700 + i);

        // R7 boundary: full 32-word fetch
        for (int i = 0; i < 32; i++) mem[10'h200 + i] = 16'h0100 + 16'(i);
        run_burst(1'b1, 32, 10'h200, -1, 1'b0);
        check(stg[31] == 16'h011F && stg[0] == 16'h0100, "R7 full burst ends", stg[31], 16'h011F);

        // R5 request during window, and same-cycle race
        run_burst(1'b0, 2, 10'h300, 10, 1'b0);
        run_burst(1'b1, 1, 10'h040, 0, 1'b0);

        // R11 retrigger during window and burst ignored
        run_burst(1'b0, 2, 10'h310, -1, 1'b1);

        // R10 mode-command start ignored
        host_we = 1'b0; host_addr = 10'h3FF;
        burst_mode = 1'b1; burst_start = 1'b1; host_req = 1'b1;
        @(negedge clk);
        burst_start = 1'b0; burst_mode = 1'b0;
        check(strobe_n == 1'b1 && !burst_busy, "R10 no window", strobe_n, 1);
        @(negedge clk);
        check(host_ack_n == 1'b0, "R10 host served", host_ack_n, 0);
        check(host_rdata == 16'h1234, "R10 read data", host_rdata, 16'h1234);
        host_req = 1'b0;
        @(negedge clk);

        // R6 acknowledged access survives a start
        host_req = 1'b1; host_addr = 10'h005;
        repeat (2) @(negedge clk);
        check(host_ack_n == 1'b0, "R6 ack before start", host_ack_n, 0);
        burst_dir = 1'b0; burst_cnt_m1 = 5'd0; burst_base = 10'h320; burst_start = 1'b1;
        @(negedge clk);
        burst_start = 1'b0;
        check(strobe_n == 1'b0, "R6 window opened", strobe_n, 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(host_ack_n == 1'b0, "R6 ack kept", host_ack_n, 0);
        end
        host_req = 1'b0;
        @(negedge clk);
        check(host_ack_n == 1'b1, "R6 ack released", host_ack_n, 1);
        for (int k = 0; k < 400 && (!strobe_n || burst_busy); k++) begin
            check(host_ack_n == 1'b1, "R6 no re-ack", host_ack_n, 1);
            @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule